// File: doc/BRIEF.md
# Vector Bitwise Logic and Select Unit

This block is the bitwise-logic datapath of a SIMD execution pipeline that works on 128-bit vector registers. On each accepted operation it combines two source vectors with a chosen logic function. Some functions also use the old value of the destination register. It registers the new destination value, which appears one cycle later with a single-cycle valid strobe.

The functions are AND, bit clear, OR, OR with inverted operand, XOR, NOT, and three merge forms: two conditional inserts and one select. The merge forms treat one vector as a per-bit mask and take the old destination as a third operand. An immediate form of an operation is issued by presenting the already expanded immediate as the second source. A half-width flag selects 64-bit register operation, and in that mode the upper 64 result bits are always cleared. Every function is purely bitwise, so the result does not depend on element size. The datapath is built as parallel lane slices.

Top module: `vec_logic_unit`

## Requirements
- R1: Opcode 0 gives a AND b, opcode 2 gives a OR b, opcode 4 gives a XOR b (a = `src_a`, b = `src_b`).
- R2: Opcode 1 (bit clear) gives a AND NOT b.
- R3: Opcode 3 gives a OR NOT b.
- R4: Opcode 5 gives NOT a; `src_b` and `dst_old` have no effect.
- R5: Opcode 6 (insert where mask set) gives d XOR ((d XOR a) AND b), where d = `dst_old`.
- R6: Opcode 7 (insert where mask clear) gives d XOR ((d XOR a) AND NOT b).
- R7: Opcode 8 (select) gives b XOR ((a XOR b) AND d), so each set bit of d picks a and each clear bit picks b.
- R8: When `half_mode` is 1, result bits 127:64 are zero for every opcode, and bits 63:0 equal the full-width result.
- R9: The result, `illegal` and `out_valid` update on the clock edge that samples `in_valid`=1. `out_valid` is high for exactly the cycle after each accepted input and low otherwise.
- R10: A cycle with `in_valid`=0 leaves `result` and `illegal` unchanged, whatever the other inputs carry.
- R11: Opcodes 9 to 15 give an all-zero result with `illegal`=1; opcodes 0 to 8 give `illegal`=0.
- R12: A synchronous active-high `rst` clears `result`, `out_valid` and `illegal` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Function code |
| half_mode | input | 1 | 1 = 64-bit register operation |
| dst_old | input | 128 | Old destination value |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector (or expanded immediate) |
| out_valid | output | 1 | One-cycle strobe for a new result |
| result | output | 128 | New destination value |
| illegal | output | 1 | Result came from an unused opcode |

## Verification
The hardest case to reach is the combination of the three-operand merge forms with half-width mode. There the old destination feeds the output directly, so a destination whose upper half is all ones would leak into bits 127:64 unless the clearing applies after the merge. The stimulus walks every opcode value in both widths. It uses patterns whose upper halves are full of ones in the destination and in both sources, so leaks become visible. It also interleaves idle cycles carrying opposite data, so a result that is not held shows up. A reset issued while a result is still valid checks that clearing takes priority over a pending operation.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 4'd0,
        OP_BCLR  = 4'd1,
        OP_OR    = 4'd2,
        OP_ORN   = 4'd3,
        OP_XOR   = 4'd4,
        OP_NOT   = 4'd5,
        OP_INS_T = 4'd6,
        OP_INS_F = 4'd7,
        OP_SEL   = 4'd8
    } vlu_op_e;

    typedef enum logic [2:0] {
        FN_ZERO,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NOT,
        FN_INS,
        FN_SEL
    } vlu_fn_e;

    typedef struct packed {
        vlu_fn_e fn;
        logic    inv_b;
        logic    legal;
    } vlu_ctrl_t;

endpackage

// File: rtl/vlu_decode.sv
module vlu_decode
    import vlu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output vlu_ctrl_t       ctrl
);

    always_comb begin
        ctrl       = '{fn: FN_ZERO, inv_b: 1'b0, legal: 1'b1};
        case (op)
            OP_AND:   ctrl.fn = FN_AND;
            OP_BCLR:  begin ctrl.fn = FN_AND; ctrl.inv_b = 1'b1; end
            OP_OR:    ctrl.fn = FN_OR;
            OP_ORN:   begin ctrl.fn = FN_OR;  ctrl.inv_b = 1'b1; end
            OP_XOR:   ctrl.fn = FN_XOR;
            OP_NOT:   ctrl.fn = FN_NOT;
            OP_INS_T: ctrl.fn = FN_INS;
            OP_INS_F: begin ctrl.fn = FN_INS; ctrl.inv_b = 1'b1; end
            OP_SEL:   ctrl.fn = FN_SEL;
            default:  begin ctrl.fn = FN_ZERO; ctrl.legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vlu_lane.sv
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int W = 32
) (
    input  vlu_fn_e      fn,
    input  logic         inv_b,
    input  logic         clr,
    input  logic [W-1:0] d,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;
    logic [W-1:0] raw;

    always_comb begin
        b_eff = inv_b ? ~b : b;
        case (fn)
            FN_AND:  raw = a & b_eff;
            FN_OR:   raw = a | b_eff;
            FN_XOR:  raw = a ^ b;
            FN_NOT:  raw = ~a;
            FN_INS:  raw = d ^ ((d ^ a) & b_eff);
            FN_SEL:  raw = b ^ ((a ^ b) & d);
            default: raw = '0;
        endcase
        y = clr ? '0 : raw;
    end

endmodule

// File: rtl/vec_logic_unit.sv
module vec_logic_unit
    import vlu_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic             half_mode,
    input  logic [VEC_W-1:0] dst_old,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             illegal
);

    localparam int LANES  = VEC_W / LANE_W;
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             vld;
        logic             ill;
    } state_t;

    vlu_ctrl_t        ctrl;
    logic [VEC_W-1:0] lane_y;
    state_t           st_d, st_q;

    vlu_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit UPPER = (g * LANE_W) >= HALF_W;
        logic clr_g;
        if (UPPER) begin : g_up
            assign clr_g = half_mode;
        end else begin : g_lo
            assign clr_g = 1'b0;
        end
        vlu_lane #(.W(LANE_W)) u_lane (
            .fn    (ctrl.fn),
            .inv_b (ctrl.inv_b),
            .clr   (clr_g),
            .d     (dst_old[g*LANE_W +: LANE_W]),
            .a     (src_a[g*LANE_W +: LANE_W]),
            .b     (src_b[g*LANE_W +: LANE_W]),
            .y     (lane_y[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = lane_y;
            st_d.ill = ~ctrl.legal;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign illegal   = st_q.ill;

endmodule

// File: rtl/vlu_chk.sv
module vlu_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic             half_mode,
    input logic [VEC_W-1:0] dst_old,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             illegal
);

    localparam int HALF_W = VEC_W / 2;

    // R9
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    strobe_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal)));

    // R8
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_mode) |=> (result[VEC_W-1:HALF_W] == '0));

    // R11
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'd9) |=> (illegal && result == '0));

    // R11
    good_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op <= 4'd8) |=> !illegal);

    // R7
    select_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !half_mode && op == 4'd8) |=>
            (result == ($past(src_b) ^ (($past(src_a) ^ $past(src_b)) & $past(dst_old)))));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal && result == '0));

endmodule

bind vec_logic_unit vlu_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .half_mode (half_mode),
    .dst_old   (dst_old),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/vec_logic_unit_bench.sv
`timescale 1ns/1ps
module vec_logic_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic         half_mode = 1'b0;
    logic [127:0] dst_old = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         illegal;

    int checks = 0;
    int failures = 0;

    logic [127:0] exp_res = '0;
    logic         exp_vld = 1'b0;
    logic         exp_ill = 1'b0;

    always #2 clk = ~clk;

    vec_logic_unit u_vec_logic_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .half_mode (half_mode),
        .dst_old   (dst_old),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result),
        .illegal   (illegal)
    );

    function automatic logic [128:0] ref_calc(input int code, input logic h,
                                              input logic [127:0] d, a, b);
        logic [127:0] r;
        logic         bad;
        bad = 1'b0;
        case (code)
            0: r = a & b;
            1: r = a & ~b;
            2: r = a | b;
            3: r = a | ~b;
            4: r = a ^ b;
            5: r = ~a;
            6: r = d ^ ((d ^ a) & b);
            7: r = d ^ ((d ^ a) & ~b);
            8: r = b ^ ((a ^ b) & d);
            default: begin r = '0; bad = 1'b1; end
        endcase
        if (h) r[127:64] = '0;
        return {bad, r};
    endfunction

    function automatic string tag_for(input logic r, input logic v,
                                      input logic h, input int code);
        if (r) return "R12";
        if (!v) return "R10";
        if (h) return "R8";
        case (code)
            0, 2, 4: return "R1";
            1: return "R2";
            3: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            8: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check_res(input string tag);
        checks++;
        if (result !== exp_res) begin
            failures++;
            $display("FAIL %s result act=%h exp=%h", tag, result, exp_res);
        end
        checks++;
        if (out_valid !== exp_vld) begin
            failures++;
            $display("FAIL R9 out_valid act=%b exp=%b", out_valid, exp_vld);
        end
        checks++;
        if (illegal !== exp_ill) begin
            failures++;
            $display("FAIL R11 illegal act=%b exp=%b (%s)", illegal, exp_ill, tag);
        end
    endtask

    // drive at negedge, model updates at the edge, compare at next negedge
    task automatic cycle(input logic r, input logic v, input int code, input logic h,
                         input logic [127:0] d, a, b);
        logic [128:0] m;
        rst = r; in_valid = v; op = 4'(code); half_mode = h;
        dst_old = d; src_a = a; src_b = b;
        @(posedge clk);
        m = ref_calc(code, h, d, a, b);
        if (r) begin
            exp_res = '0; exp_vld = 1'b0; exp_ill = 1'b0;
        end else begin
            exp_vld = v;
            if (v) begin
                exp_res = m[127:0];
                exp_ill = m[128];
            end
        end
        @(negedge clk);
        check_res(tag_for(r, v, h, code));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] pd [4];
        logic [127:0] pa [4];
        logic [127:0] pb [4];
        pd[0] = {128{1'b1}};  pa[0] = '0;            pb[0] = {64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F};
        pd[1] = '0;           pa[1] = {128{1'b1}};   pb[1] = {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555};
        pd[2] = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
        pa[2] = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210};
        pb[2] = {64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_00FF_F0F0_3C3C};
        pd[3] = {32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 32'h8765_4321};
        pa[3] = {32'h0F1E_2D3C, 32'h4B5A_6978, 32'h8796_A5B4, 32'hC3D2_E1F0};
        pb[3] = {32'hFFFF_0000, 32'h00FF_FF00, 32'hF00F_0FF0, 32'h3333_CCCC};

        @(negedge clk);
        // R12 reset state
        cycle(1'b1, 1'b0, 0, 1'b0, '0, '0, '0);
        cycle(1'b1, 1'b1, 2, 1'b0, pd[0], pa[1], pb[1]);

        // every opcode in both widths, R1..R8 and R11
        for (int h = 0; h < 2; h++)
            for (int c = 0; c < 16; c++)
                for (int p = 0; p < 4; p++)
                    cycle(1'b0, 1'b1, c, h[0], pd[p], pa[p], pb[p]);

        // R10 idle cycles with unrelated data after legal and illegal results
        cycle(1'b0, 1'b1, 8, 1'b0, pd[3], pa[3], pb[3]);
        for (int k = 0; k < 4; k++)
            cycle(1'b0, 1'b0, k * 3, k[0], ~pd[3], ~pa[3], ~pb[3]);
        cycle(1'b0, 1'b1, 13, 1'b0, pd[2], pa[2], pb[2]);
        for (int k = 0; k < 3; k++)
            cycle(1'b0, 1'b0, 0, 1'b0, rnd128(), rnd128(), rnd128());

        // R4 NOT ignores src_b and dst_old
        cycle(1'b0, 1'b1, 5, 1'b0, pd[0], pa[3], pb[0]);
        cycle(1'b0, 1'b1, 5, 1'b0, pd[1], pa[3], pb[1]);

        // R8 merges with full upper halves in half-width mode
        cycle(1'b0, 1'b1, 6, 1'b1, {128{1'b1}}, {128{1'b1}}, {128{1'b1}});
        cycle(1'b0, 1'b1, 7, 1'b1, {128{1'b1}}, '0, '0);
        cycle(1'b0, 1'b1, 8, 1'b1, {128{1'b1}}, {128{1'b1}}, '0);

        // R9 single strobe, back-to-back strobes, gaps
        cycle(1'b0, 1'b0, 0, 1'b0, '0, '0, '0);
        cycle(1'b0, 1'b1, 4, 1'b0, pd[2], pa[2], pb[3]);
        cycle(1'b0, 1'b0, 4, 1'b0, pd[2], pa[2], pb[3]);
        cycle(1'b0, 1'b1, 0, 1'b0, pd[1], pa[1], pb[1]);
        cycle(1'b0, 1'b1, 2, 1'b0, pd[1], pa[0], pb[0]);

        // R12 reset while a result is pending
        cycle(1'b0, 1'b1, 15, 1'b0, pd[0], pa[0], pb[0]);
        cycle(1'b1, 1'b1, 3, 1'b0, pd[2], pa[2], pb[2]);
        cycle(1'b0, 1'b0, 3, 1'b0, pd[2], pa[2], pb[2]);

        // random traffic
        for (int k = 0; k < 2000; k++)
            cycle(1'b0, ($urandom % 4) != 0, int'($urandom % 16), 1'($urandom % 2),
                  rnd128(), rnd128(), rnd128());

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule